// File: doc/BRIEF.md
# Serial Four-Bit Group Parity Checker

This block watches a serial data line that carries one bit per clock, qualified by a valid strobe. It cuts the stream into back-to-back groups of four accepted bits and, each time a group is finished, reports whether that group held an odd number of ones. The error output is a registered level. It changes only on the clock edge that accepts the last bit of a group, and it keeps that value until the next group completes.

Inside, a small position counter marks where the next bit falls in its group. A one-bit accumulator folds each accepted bit into a running exclusive-OR. A flag register captures the final parity at the group boundary. Clocks without the valid strobe leave all three untouched, so gaps in the stream only stretch a group in time. The group length is a parameter with a default of four, and the counter width follows from it.

Top module: `ser_grp_parity_chk`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, `err_o` is 0 after that edge, and the next accepted bit is the first bit of a new group.
- R2: On the edge that accepts the fourth bit of a group, `err_o` becomes 1 if the group's four accepted bits contain an odd number of ones, and 0 otherwise.
- R3: `err_o` keeps its value on every edge that does not accept the fourth bit of a group.
- R4: A clock with `bit_vld` at 0 neither advances the group position nor changes the running parity, whatever value `bit_in` has.
- R5: Groups with an even count of ones, such as 0000, 1111 and 0110, drive `err_o` to 0.
- R6: The groups 1011 and 0100 each drive `err_o` to 1.
- R7: The running parity starts from 0 for every group, so the bits of earlier groups have no effect on a later group's result.
- R8: A reset in the middle of a group discards the bits already accepted in it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | High when `bit_in` carries a bit to accept |
| err_o | output | 1 | Odd-parity flag for the most recently completed group |

## Verification
The fixed groups 1011 and 0100 must raise the flag, and 0000, 1111 and 0110 must clear it. Together they separate a true parity from an OR, an AND or a plain count of ones. A group split by invalid cycles, with `bit_in` held at 1 during the gaps, shows that gap cycles neither advance the position nor add ones. A long stretch of invalid toggling shows that the flag holds. A reset after two accepted bits shows that partial groups are discarded. Several hundred random groups, with the strobe dropped at random, then check that the parity restarts at each boundary and that the flag changes on the right edge.

// File: rtl/ser_grp_pkg.sv
// Shared definitions for the serial group parity checker.
// Assumes: group length is at least 2 so the position counter has width.
package ser_grp_pkg;
    localparam int GRP_LEN_DFLT = 4;

    // One serial sample with its qualifier
    typedef struct packed {
        logic vld;
        logic dat;
    } ser_bit_t;
endpackage

// File: rtl/ser_grp_pos_cnt.sv
// Position counter: counts accepted bits within a group and flags the last slot.
// Assumes: adv is high only on clocks where a bit is accepted.
module ser_grp_pos_cnt #(
    parameter int GRP_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic last
);
    localparam int CNT_W = (GRP_LEN > 2) ? $clog2(GRP_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(GRP_LEN - 1);

    logic [CNT_W-1:0] pos_q;

    // Advance on each accepted bit, wrapping after the last slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (adv) begin
            if (pos_q == LAST_POS) pos_q <= '0;
            else                   pos_q <= pos_q + 1'b1;
        end
    end

    assign last = (pos_q == LAST_POS);

    AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(pos_q)); // R4
    AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && last) |=> (pos_q == '0)); // R2
endmodule

// File: rtl/ser_grp_par_acc.sv
// Running parity accumulator: XOR of the bits accepted so far in the group.
// Assumes: clr is asserted together with adv on the last bit of the group.
module ser_grp_par_acc (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic dat,
    input  logic clr,
    output logic par_nxt
);
    logic acc_q;

    // Parity including the bit on the line this clock
    assign par_nxt = acc_q ^ dat;

    // Fold in accepted bits; restart from zero at a group boundary
    always_ff @(posedge clk) begin
        if (!rst_n)        acc_q <= 1'b0;
        else if (adv)      acc_q <= clr ? 1'b0 : par_nxt;
    end

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(acc_q)); // R4
    AST_ACC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && clr) |=> (acc_q == 1'b0)); // R7
endmodule

// File: rtl/ser_grp_err_reg.sv
// Error flag register: captures the group parity at each group boundary.
// Assumes: load pulses exactly on the edge accepting a group's last bit.
module ser_grp_err_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic par_in,
    output logic err
);
    // Update only at group completion, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)    err <= 1'b0;
        else if (load) err <= par_in;
    end

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(err)); // R3
endmodule

// File: rtl/ser_grp_parity_chk.sv
// Serial group parity checker top: splits a qualified serial stream into
// fixed-length groups and flags any completed group with odd parity.
// Assumes: synchronous active-low reset; the bit is taken when bit_vld is high.
module ser_grp_parity_chk #(
    parameter int GRP_LEN = ser_grp_pkg::GRP_LEN_DFLT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_vld,
    output logic err_o
);
    import ser_grp_pkg::*;

    ser_bit_t smp;
    logic     grp_last;
    logic     par_nxt;
    logic     grp_done;

    assign smp      = '{vld: bit_vld, dat: bit_in};
    assign grp_done = smp.vld && grp_last;

    ser_grp_pos_cnt #(.GRP_LEN(GRP_LEN)) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (smp.vld),
        .last  (grp_last)
    );

    ser_grp_par_acc u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (smp.vld),
        .dat     (smp.dat),
        .clr     (grp_last),
        .par_nxt (par_nxt)
    );

    ser_grp_err_reg u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (grp_done),
        .par_in (par_nxt),
        .err    (err_o)
    );

    AST_RST_CLEAR: assert property (@(posedge clk)
        !rst_n |=> !err_o); // R1
    AST_NO_VLD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(err_o)); // R4
endmodule

// File: tb/ser_grp_parity_chk_test.sv
module ser_grp_parity_chk_test;
    localparam int CLK_PERIOD = 10;
    localparam int GRP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0;
    logic bit_vld = 1'b0;
    logic err_o;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Reference model state
    int m_pos = 0;
    int m_ones = 0;
    logic m_err = 1'b0;

    ser_grp_parity_chk #(.GRP_LEN(GRP)) uut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld), .err_o(err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Drive one clock, update the model at the edge, compare after it
    task automatic step(input logic rn, input logic v, input logic b, input string tag);
        @(negedge clk);
        rst_n = rn; bit_vld = v; bit_in = b;
        @(posedge clk);
        if (!rn) begin
            m_pos = 0; m_ones = 0; m_err = 1'b0;
        end else if (v) begin
            m_ones += b;
            m_pos++;
            if (m_pos == GRP) begin
                m_err = logic'(m_ones % 2);
                m_pos = 0; m_ones = 0;
            end
        end
        #1;
        n_vec++;
        if (err_o !== m_err) begin
            n_bad++;
            $display("FAIL %s: err_o=%0b expected %0b at %0t", tag, err_o, m_err, $time);
        end
    endtask

    task automatic group4(input logic [3:0] g, input string tag);
        for (int i = 3; i >= 0; i--) step(1'b1, 1'b1, g[i], tag);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, "R1");
        group4(4'b1011, "R6");
        group4(4'b0100, "R6");
        group4(4'b0000, "R5");
        group4(4'b1011, "R6");
        group4(4'b1111, "R5");
        group4(4'b0100, "R6");
        group4(4'b0110, "R5");
        // Group split by gaps with the data line held high
        step(1'b1, 1'b1, 1'b1, "R4");
        step(1'b1, 1'b0, 1'b1, "R4");
        step(1'b1, 1'b0, 1'b1, "R4");
        step(1'b1, 1'b1, 1'b0, "R4");
        step(1'b1, 1'b0, 1'b1, "R4");
        step(1'b1, 1'b1, 1'b1, "R4");
        step(1'b1, 1'b1, 1'b1, "R4");
        // Flag holds through idle toggling
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0, logic'(i % 2), "R3");
        // Reset after two accepted bits discards them
        step(1'b1, 1'b1, 1'b1, "R8");
        step(1'b1, 1'b1, 1'b1, "R8");
        step(1'b0, 1'b0, 1'b0, "R1");
        group4(4'b1000, "R8");
        group4(4'b1100, "R7");
        // Random groups with random gaps
        for (int i = 0; i < 1600; i++)
            step(1'b1, logic'($urandom_range(0, 3) != 0), logic'($urandom_range(0, 1)), "R7");
        for (int i = 0; i < 400; i++)
            step(1'b1, 1'b1, logic'($urandom_range(0, 1)), "R2");
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: finished=0 expected 1");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule